// File: doc/BRIEF.md
# Serial Bus Slave Frame Receiver

This block sits on the slave side of a single-wire, master-scheduled serial bus. The bit period is already known and is given as a count of clock cycles. The block watches the receive line and recognises a long dominant run as the start of a header. It then takes a synchronisation byte and a parity-protected identifier byte. Once the identifier is accepted, it reads the data field and a closing check byte. The data field length is not carried on the wire. It is taken from a small table, written over a simple port, that holds one length per identifier.

The six-bit identifier sorts each frame into one of four classes: signal, diagnostic master request, diagnostic slave response, and user-defined. The class decides which bytes the checksum covers. The one reserved identifier is dropped without any report. When a frame is complete and correct, the block publishes the identifier, the class, the length and the data bytes together with a one-cycle strobe. Every failure instead gives a one-cycle error pulse of its own kind. A master-request frame whose first data byte is zero also raises a sleep-command pulse.

Top module: `lin_frame_rx`

## Requirements
- R1: A frame starts only after the line has been dominant (0) for at least BREAK_BITS bit times (default 11). A shorter dominant run, and everything that follows it up to the next valid break, produces neither a strobe nor an error.
- R2: After a break, if the first byte is not 0x55, or if any byte of the frame has its stop bit sampled dominant, `err_framing` pulses for one cycle and the frame is dropped.
- R3: In the identifier byte, bits 5:0 are the identifier, bit 6 is id0^id1^id2^id4 and bit 7 is ~(id1^id3^id4^id5). If either parity bit is wrong, `err_parity` pulses and the frame is dropped.
- R4: The `out_class` encoding is: 0 for identifiers 0..59 (signal), 1 for 60 (master request), 2 for 61 (slave response), 3 for 62 (user-defined). A frame with identifier 63 is dropped with no strobe and no error.
- R5: The length table holds one 3-bit code per identifier, and the data length is the code plus 1. A table entry is written when `len_we` is high, at `len_addr` with `len_code`. After reset every entry reads as code 7 (8 bytes). The table is read at the moment the identifier byte is accepted.
- R6: The check byte is the bitwise inverse of the 8-bit sum, with end-around carry, of the covered bytes. For identifiers 60 and 61 the sum covers the data bytes only. For all other identifiers it also covers the identifier byte. On a mismatch, `err_checksum` pulses and the frame is dropped.
- R7: On a correct check byte, `frame_valid` pulses for one cycle. In that same cycle `out_id`, `out_class`, `out_len` and `out_data` take the new frame, with data byte k at `out_data[8k+7:8k]` and the bytes beyond the length set to zero. These outputs then hold until the next strobe.
- R8: `sleep_cmd` pulses in the same cycle as `frame_valid` when the identifier is 60 and data byte 0 is 0x00. In every other case it stays low.
- R9: Each byte on the line is a dominant start bit, then eight data bits sent least significant bit first, then a recessive stop bit. Every bit is sampled at its middle, and the idle line is recessive (1).
- R10: During and right after reset, every output is zero.
- R11: In any one cycle, at most one of `frame_valid`, `err_parity`, `err_framing` and `err_checksum` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx | input | 1 | Receive line, 1 = recessive |
| len_we | input | 1 | Length-table write enable |
| len_addr | input | 6 | Identifier whose length entry is written |
| len_code | input | 3 | Length code to write (length minus 1) |
| frame_valid | output | 1 | One-cycle strobe for a correct frame |
| out_id | output | 6 | Identifier of the last correct frame |
| out_class | output | 2 | Class of the last correct frame |
| out_len | output | 4 | Data byte count of the last correct frame |
| out_data | output | 64 | Data bytes of the last correct frame |
| err_parity | output | 1 | Identifier parity error pulse |
| err_framing | output | 1 | Bad sync or dominant stop bit pulse |
| err_checksum | output | 1 | Check byte mismatch pulse |
| sleep_cmd | output | 1 | Go-to-sleep command pulse |

## Verification
Completion and the sleep command come out in the same cycle, because both are decided by the check byte of a master-request frame. The bench provokes this by sending identifier 60 with a zero first byte and a correct checksum. It then counts the cycles in which the strobe and the sleep pulse are both high, and the count must be exactly one. To show the pairing is not simply tied together, the bench sends the same frame with a corrupted check byte: the checksum error must then appear with no sleep pulse. It also sends identifier 61 with a zero first byte and a good checksum: the strobe must appear, again with no sleep pulse.

// File: rtl/lin_rx_pkg.sv
package lin_rx_pkg;
  localparam int ID_W       = 6;
  localparam int NUM_IDS    = 1 << ID_W;
  localparam int MAX_BYTES  = 8;
  localparam int LEN_CODE_W = $clog2(MAX_BYTES);
  localparam int LEN_W      = LEN_CODE_W + 1;
  localparam int DATA_W     = 8 * MAX_BYTES;
  localparam int DIDX_W     = $clog2(DATA_W);
  localparam logic [7:0] SYNC_VAL = 8'h55;
  localparam logic [ID_W-1:0] ID_MREQ  = 6'd60;
  localparam logic [ID_W-1:0] ID_SRESP = 6'd61;
  localparam logic [ID_W-1:0] ID_USER  = 6'd62;
  localparam logic [ID_W-1:0] ID_RSVD  = 6'd63;

  typedef enum logic [1:0] {
    CL_SIGNAL = 2'd0,
    CL_MREQ   = 2'd1,
    CL_SRESP  = 2'd2,
    CL_USER   = 2'd3
  } frame_class_t;

  typedef enum logic [2:0] {
    S_HUNT, S_SYNC, S_PID, S_DATA, S_CSUM
  } rx_state_t;

  // identifier with both parity bits attached
  function automatic logic [7:0] protect_id(input logic [ID_W-1:0] id);
    logic p0, p1;
    p0 = id[0] ^ id[1] ^ id[2] ^ id[4];
    p1 = ~(id[1] ^ id[3] ^ id[4] ^ id[5]);
    return {p1, p0, id};
  endfunction

  function automatic frame_class_t classify(input logic [ID_W-1:0] id);
    if (id == ID_MREQ)       return CL_MREQ;
    else if (id == ID_SRESP) return CL_SRESP;
    else if (id == ID_USER)  return CL_USER;
    else                     return CL_SIGNAL;
  endfunction

  // diagnostic frames leave the identifier out of the sum
  function automatic logic data_only_sum(input logic [ID_W-1:0] id);
    return (id == ID_MREQ) || (id == ID_SRESP);
  endfunction

  // 8-bit add with the carry folded back in
  function automatic logic [7:0] csum_add(input logic [7:0] acc, input logic [7:0] b);
    logic [8:0] s;
    s = {1'b0, acc} + {1'b0, b};
    return s[7:0] + {7'd0, s[8]};
  endfunction
endpackage

// File: rtl/lin_bit_rx.sv
module lin_bit_rx #(
  parameter int CLKS_PER_BIT = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx,
  output logic       rx_s,
  output logic       byte_vld,
  output logic [7:0] byte_data,
  output logic       byte_ferr
);
  localparam int CNT_W = $clog2(CLKS_PER_BIT);
  localparam logic [CNT_W-1:0] FULL_M1 = CNT_W'(CLKS_PER_BIT - 1);
  localparam logic [CNT_W-1:0] HALF_M1 = CNT_W'(CLKS_PER_BIT / 2 - 1);

  typedef enum logic [2:0] {B_IDLE, B_START, B_DATA, B_STOP, B_WAITHI} bstate_t;

  logic       rx_m;
  bstate_t    bst;
  logic [CNT_W-1:0] cnt;
  logic [2:0] bitn;
  logic [7:0] sh;
  logic       tick;

  assign tick = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_m <= 1'b1;
      rx_s <= 1'b1;
    end else begin
      rx_m <= rx;
      rx_s <= rx_m;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bst       <= B_IDLE;
      cnt       <= '0;
      bitn      <= '0;
      sh        <= '0;
      byte_vld  <= 1'b0;
      byte_data <= '0;
      byte_ferr <= 1'b0;
    end else begin
      byte_vld  <= 1'b0;
      byte_ferr <= 1'b0;
      if (!tick) cnt <= cnt - 1'b1;
      unique case (bst)
        B_IDLE: if (!rx_s) begin
          bst <= B_START;
          cnt <= HALF_M1;
        end
        B_START: if (tick) begin
          if (!rx_s) begin
            bst  <= B_DATA;
            cnt  <= FULL_M1;
            bitn <= '0;
          end else begin
            bst <= B_IDLE;
          end
        end
        B_DATA: if (tick) begin
          sh   <= {rx_s, sh[7:1]};
          cnt  <= FULL_M1;
          bitn <= bitn + 1'b1;
          if (bitn == 3'd7) bst <= B_STOP;
        end
        B_STOP: if (tick) begin
          byte_vld  <= 1'b1;
          byte_data <= sh;
          byte_ferr <= !rx_s;
          bst       <= rx_s ? B_IDLE : B_WAITHI;
        end
        B_WAITHI: if (rx_s) bst <= B_IDLE;
        default: bst <= B_IDLE;
      endcase
    end
  end

  // R9: a byte reported without a framing flag had a recessive stop sample
  p_stop_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && !byte_ferr) |-> $past(rx_s));
endmodule

// File: rtl/lin_brk_det.sv
module lin_brk_det #(
  parameter int CLKS_PER_BIT = 16,
  parameter int BREAK_BITS   = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_s,
  output logic brk_pulse
);
  localparam int BRK_CYC = CLKS_PER_BIT * BREAK_BITS;
  localparam int RUN_W   = $clog2(BRK_CYC + 1);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(BRK_CYC);

  logic [RUN_W-1:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run       <= '0;
      brk_pulse <= 1'b0;
    end else begin
      brk_pulse <= 1'b0;
      if (rx_s) begin
        run <= '0;
      end else if (run != RUN_MAX) begin
        run <= run + 1'b1;
        if (run == RUN_MAX - 1'b1) brk_pulse <= 1'b1;
      end
    end
  end

  // R1: a break is only ever flagged while the line is dominant
  p_brk_dominant_r1: assert property (@(posedge clk) disable iff (!rst_n)
    brk_pulse |-> !$past(rx_s));
endmodule

// File: rtl/lin_len_table.sv
module lin_len_table
  import lin_rx_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [ID_W-1:0]       waddr,
  input  logic [LEN_CODE_W-1:0] wcode,
  input  logic [ID_W-1:0]       raddr,
  output logic [LEN_W-1:0]      rlen
);
  logic [LEN_CODE_W-1:0] codes [NUM_IDS];

  for (genvar g = 0; g < NUM_IDS; g++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          codes[g] <= '1;
      else if (we && waddr == ID_W'(g))    codes[g] <= wcode;
    end
  end

  assign rlen = {1'b0, codes[raddr]} + LEN_W'(1);
endmodule

// File: rtl/lin_frame_fsm.sv
module lin_frame_fsm
  import lin_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_vld,
  input  logic [7:0]        byte_data,
  input  logic              byte_ferr,
  input  logic              brk_pulse,
  input  logic [LEN_W-1:0]  tbl_len,
  output logic              frame_valid,
  output logic [ID_W-1:0]   out_id,
  output logic [1:0]        out_class,
  output logic [LEN_W-1:0]  out_len,
  output logic [DATA_W-1:0] out_data,
  output logic              err_parity,
  output logic              err_framing,
  output logic              err_checksum,
  output logic              sleep_cmd
);
  rx_state_t          st;
  logic [ID_W-1:0]    id_r;
  frame_class_t       cls_r;
  logic [LEN_W-1:0]   len_r;
  logic [LEN_W-1:0]   idx;
  logic [7:0]         acc;
  logic [DATA_W-1:0]  stage;

  // named events for the checks below
  logic pid_ok, pid_rsvd, last_data, csum_ok;
  logic [DIDX_W-1:0] slot;

  assign pid_ok    = (byte_data == protect_id(byte_data[ID_W-1:0]));
  assign pid_rsvd  = (byte_data[ID_W-1:0] == ID_RSVD);
  assign last_data = (idx == len_r - LEN_W'(1));
  assign csum_ok   = (byte_data == ~acc);
  assign slot      = {idx[LEN_CODE_W-1:0], 3'b000};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= S_HUNT;
      id_r         <= '0;
      cls_r        <= CL_SIGNAL;
      len_r        <= '0;
      idx          <= '0;
      acc          <= '0;
      stage        <= '0;
      frame_valid  <= 1'b0;
      out_id       <= '0;
      out_class    <= '0;
      out_len      <= '0;
      out_data     <= '0;
      err_parity   <= 1'b0;
      err_framing  <= 1'b0;
      err_checksum <= 1'b0;
      sleep_cmd    <= 1'b0;
    end else begin
      frame_valid  <= 1'b0;
      err_parity   <= 1'b0;
      err_framing  <= 1'b0;
      err_checksum <= 1'b0;
      sleep_cmd    <= 1'b0;
      if (byte_vld && st != S_HUNT) begin
        if (byte_ferr) begin
          err_framing <= 1'b1;
          st          <= S_HUNT;
        end else begin
          unique case (st)
            S_SYNC: begin
              if (byte_data == SYNC_VAL) st <= S_PID;
              else begin
                err_framing <= 1'b1;
                st          <= S_HUNT;
              end
            end
            S_PID: begin
              if (!pid_ok) begin
                err_parity <= 1'b1;
                st         <= S_HUNT;
              end else if (pid_rsvd) begin
                st <= S_HUNT;
              end else begin
                id_r  <= byte_data[ID_W-1:0];
                cls_r <= classify(byte_data[ID_W-1:0]);
                len_r <= tbl_len;
                idx   <= '0;
                stage <= '0;
                acc   <= data_only_sum(byte_data[ID_W-1:0]) ? 8'h00 : byte_data;
                st    <= S_DATA;
              end
            end
            S_DATA: begin
              stage[slot +: 8] <= byte_data;
              acc              <= csum_add(acc, byte_data);
              idx              <= idx + 1'b1;
              if (last_data) st <= S_CSUM;
            end
            S_CSUM: begin
              if (csum_ok) begin
                frame_valid <= 1'b1;
                out_id      <= id_r;
                out_class   <= cls_r;
                out_len     <= len_r;
                out_data    <= stage;
                sleep_cmd   <= (cls_r == CL_MREQ) && (stage[7:0] == 8'h00);
              end else begin
                err_checksum <= 1'b1;
              end
              st <= S_HUNT;
            end
            default: st <= S_HUNT;
          endcase
        end
      end
      if (brk_pulse) st <= S_SYNC;
    end
  end

  // R11: outcomes are exclusive
  p_one_outcome_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({frame_valid, err_parity, err_framing, err_checksum}));
  // R8: sleep only rides on a completed master request with a zero first byte
  p_sleep_pair_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_cmd |-> (frame_valid && out_id == ID_MREQ && out_data[7:0] == 8'h00));
  // R7: published frame holds between strobes
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_valid |-> ($stable(out_id) && $stable(out_data) && $stable(out_len)));
  // R3: a parity failure leaves the receiver hunting
  p_parity_hunt_r3: assert property (@(posedge clk) disable iff (!rst_n)
    err_parity |-> (st == S_HUNT));
  // R5: lengths published are within 1..MAX_BYTES
  p_len_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |-> (out_len >= LEN_W'(1) && out_len <= LEN_W'(MAX_BYTES)));
  // R4: reserved identifier never completes
  p_no_rsvd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |-> (out_id != ID_RSVD));
endmodule

// File: rtl/lin_frame_rx.sv
module lin_frame_rx
  import lin_rx_pkg::*;
#(
  parameter int CLKS_PER_BIT = 16,
  parameter int BREAK_BITS   = 11
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx,
  input  logic        len_we,
  input  logic [5:0]  len_addr,
  input  logic [2:0]  len_code,
  output logic        frame_valid,
  output logic [5:0]  out_id,
  output logic [1:0]  out_class,
  output logic [3:0]  out_len,
  output logic [63:0] out_data,
  output logic        err_parity,
  output logic        err_framing,
  output logic        err_checksum,
  output logic        sleep_cmd
);
  logic             rx_s;
  logic             byte_vld;
  logic [7:0]       byte_data;
  logic             byte_ferr;
  logic             brk_pulse;
  logic [LEN_W-1:0] tbl_len;

  lin_bit_rx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_bit (
    .clk(clk), .rst_n(rst_n), .rx(rx), .rx_s(rx_s),
    .byte_vld(byte_vld), .byte_data(byte_data), .byte_ferr(byte_ferr)
  );

  lin_brk_det #(.CLKS_PER_BIT(CLKS_PER_BIT), .BREAK_BITS(BREAK_BITS)) u_brk (
    .clk(clk), .rst_n(rst_n), .rx_s(rx_s), .brk_pulse(brk_pulse)
  );

  lin_len_table u_tbl (
    .clk(clk), .rst_n(rst_n), .we(len_we), .waddr(len_addr), .wcode(len_code),
    .raddr(byte_data[ID_W-1:0]), .rlen(tbl_len)
  );

  lin_frame_fsm u_fsm (
    .clk(clk), .rst_n(rst_n),
    .byte_vld(byte_vld), .byte_data(byte_data), .byte_ferr(byte_ferr),
    .brk_pulse(brk_pulse), .tbl_len(tbl_len),
    .frame_valid(frame_valid), .out_id(out_id), .out_class(out_class),
    .out_len(out_len), .out_data(out_data),
    .err_parity(err_parity), .err_framing(err_framing),
    .err_checksum(err_checksum), .sleep_cmd(sleep_cmd)
  );
endmodule

// File: tb/tb_lin_frame_rx.sv
module tb_lin_frame_rx;
  localparam int CPB = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx = 1'b1;
  logic len_we = 1'b0;
  logic [5:0] len_addr = '0;
  logic [2:0] len_code = '0;
  logic frame_valid, err_parity, err_framing, err_checksum, sleep_cmd;
  logic [5:0] out_id;
  logic [1:0] out_class;
  logic [3:0] out_len;
  logic [63:0] out_data;

  always #4 clk = ~clk;

  lin_frame_rx #(.CLKS_PER_BIT(CPB), .BREAK_BITS(11)) dut (
    .clk(clk), .rst_n(rst_n), .rx(rx), .len_we(len_we), .len_addr(len_addr),
    .len_code(len_code), .frame_valid(frame_valid), .out_id(out_id),
    .out_class(out_class), .out_len(out_len), .out_data(out_data),
    .err_parity(err_parity), .err_framing(err_framing),
    .err_checksum(err_checksum), .sleep_cmd(sleep_cmd)
  );

  int total = 0, bad = 0;
  int n_valid = 0, n_ep = 0, n_ef = 0, n_ec = 0, n_sleep = 0, n_both = 0;
  logic [7:0] fb [0:10];
  int nfb;
  logic [7:0] dbytes [0:7];

  always @(negedge clk) begin
    if (frame_valid) n_valid++;
    if (err_parity) n_ep++;
    if (err_framing) n_ef++;
    if (err_checksum) n_ec++;
    if (sleep_cmd) n_sleep++;
    if (frame_valid && sleep_cmd) n_both++;
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] tb_pid(input int id);
    logic [5:0] i;
    i = 6'(id);
    return {~(^(i & 6'h3A)), ^(i & 6'h17), i};
  endfunction

  function automatic logic [7:0] tb_csum(input int id, input logic [7:0] pid, input int n);
    int s;
    s = (id == 60 || id == 61) ? 0 : int'(pid);
    for (int k = 0; k < n; k++) begin
      s = s + int'(dbytes[k]);
      if (s > 255) s = s - 255;
    end
    return ~(8'(s));
  endfunction

  function automatic logic [63:0] tb_data(input int n);
    logic [63:0] d;
    d = '0;
    for (int k = 0; k < n; k++) d[8*k +: 8] = dbytes[k];
    return d;
  endfunction

  // fb: sync, pid, data..., check byte
  task automatic build(input int id, input logic [7:0] pid, input int n, input logic [7:0] csum_xor);
    fb[0] = 8'h55;
    fb[1] = pid;
    for (int k = 0; k < n; k++) fb[2+k] = dbytes[k];
    fb[2+n] = tb_csum(id, pid, n) ^ csum_xor;
    nfb = n + 3;
  endtask

  task automatic send_byte(input logic [7:0] b, input logic stop);
    rx = 1'b0;
    repeat (CPB) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx = b[i];
      repeat (CPB) @(negedge clk);
    end
    rx = stop;
    repeat (CPB) @(negedge clk);
  endtask

  task automatic send(input int brk_bits, input int bad_stop);
    @(posedge clk);
    n_valid = 0; n_ep = 0; n_ef = 0; n_ec = 0; n_sleep = 0; n_both = 0;
    @(negedge clk);
    rx = 1'b0;
    repeat (brk_bits * CPB) @(negedge clk);
    rx = 1'b1;
    repeat (CPB) @(negedge clk);
    for (int i = 0; i < nfb; i++) send_byte(fb[i], i != bad_stop);
    rx = 1'b1;
    repeat (4 * CPB) @(negedge clk);
  endtask

  task automatic fill(input int id);
    for (int k = 0; k < 8; k++) dbytes[k] = 8'((id * 7 + k * 13 + 1) & 255);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 valid", {63'd0, frame_valid}, 64'd0);
    chk("R10 outs", {out_id, out_class, out_len, err_parity, err_framing, err_checksum, sleep_cmd}, 64'd0);
    chk("R10 data", out_data, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10 after release", {out_id, out_len, frame_valid}, 64'd0);

    // R5: reset default length is 8
    fill(10);
    build(10, tb_pid(10), 8, 8'h00);
    send(13, -1);
    chk("R5 default valid", 64'(n_valid), 64'd1);
    chk("R5 default len", 64'(out_len), 64'd8);
    chk("R9 default data", out_data, tb_data(8));

    // R5: program length table, code = id % 8
    for (int a = 0; a < 64; a++) begin
      len_we = 1'b1; len_addr = 6'(a); len_code = 3'(a % 8);
      @(negedge clk);
    end
    len_we = 1'b0;

    // sweep every identifier
    for (int id = 0; id < 64; id++) begin
      int n;
      n = id % 8 + 1;
      fill(id);
      build(id, tb_pid(id), n, 8'h00);
      send(13, -1);
      chk("R11 errors", 64'(n_ep + n_ef + n_ec), 64'd0);
      chk("R8 no sleep", 64'(n_sleep), 64'd0);
      if (id == 63) begin
        chk("R4 reserved dropped", 64'(n_valid), 64'd0);
      end else begin
        chk("R7 valid", 64'(n_valid), 64'd1);
        chk("R3 id", 64'(out_id), 64'(id));
        chk("R4 class", 64'(out_class), (id < 60) ? 64'd0 : 64'(id - 59));
        chk("R5 len", 64'(out_len), 64'(n));
        chk("R6 data", out_data, tb_data(n));
      end
    end

    // R3: parity error
    fill(20);
    build(20, tb_pid(20) ^ 8'h80, 5, 8'h00);
    send(13, -1);
    chk("R3 parity err", 64'(n_ep), 64'd1);
    chk("R3 no valid", 64'(n_valid), 64'd0);
    build(20, tb_pid(20) ^ 8'h40, 5, 8'h00);
    send(13, -1);
    chk("R3 p0 err", 64'(n_ep), 64'd1);

    // R6: checksum error, outputs hold (last good frame was 62)
    fill(5);
    build(5, tb_pid(5), 6, 8'h01);
    send(13, -1);
    chk("R6 csum err", 64'(n_ec), 64'd1);
    chk("R6 no valid", 64'(n_valid), 64'd0);
    chk("R7 hold id", 64'(out_id), 64'd62);

    // R2: sync wrong
    fill(3);
    build(3, tb_pid(3), 4, 8'h00);
    fb[0] = 8'h54;
    send(13, -1);
    chk("R2 bad sync", 64'(n_ef), 64'd1);
    chk("R2 no valid", 64'(n_valid), 64'd0);

    // R2: dominant stop in a data byte
    for (int k = 0; k < 8; k++) dbytes[k] = 8'hA5;
    build(3, tb_pid(3), 4, 8'h00);
    send(13, 3);
    chk("R2 stop dominant", 64'(n_ef), 64'd1);
    chk("R2 stop no valid", 64'(n_valid), 64'd0);

    // R1: break too short
    fill(7);
    build(7, tb_pid(7), 8, 8'h00);
    send(10, -1);
    chk("R1 short break valid", 64'(n_valid), 64'd0);
    chk("R1 short break errs", 64'(n_ep + n_ef + n_ec), 64'd0);
    send(11, -1);
    chk("R1 min break valid", 64'(n_valid), 64'd1);

    // R8: sleep command together with completion
    fill(60);
    dbytes[0] = 8'h00;
    build(60, tb_pid(60), 5, 8'h00);
    send(13, -1);
    chk("R8 sleep", 64'(n_sleep), 64'd1);
    chk("R8 same cycle", 64'(n_both), 64'd1);
    chk("R6 classic sum valid", 64'(n_valid), 64'd1);
    build(60, tb_pid(60), 5, 8'h10);
    send(13, -1);
    chk("R8 bad csum no sleep", 64'(n_sleep), 64'd0);
    chk("R8 bad csum err", 64'(n_ec), 64'd1);
    fill(61);
    dbytes[0] = 8'h00;
    build(61, tb_pid(61), 6, 8'h00);
    send(13, -1);
    chk("R8 id61 valid", 64'(n_valid), 64'd1);
    chk("R8 id61 no sleep", 64'(n_sleep), 64'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule